// File: doc/BRIEF.md
# Branch Target Stream Fetch Unit

This unit fetches instructions for a code-only memory that is quick only when it walks forward one word at a time inside an open row. Each random access is slow. While the program counter counts up, the unit passes one 32-bit word per cycle from the memory's sequential read stream to the instruction output, and no lookup takes place.

To hide the slow access after a taken branch, the unit keeps a small fully associative store. Each entry is tagged by a branch target address and holds the first few words of the code that starts there. On a redirect that hits, the unit opens memory at the address just past the cached words. It plays the cached words out while that access is in flight, then continues from the memory stream. On a miss it opens memory at the target, stalls until data arrives, and records the first words into an entry chosen round-robin. When sequential fetch leaves the last word of a row, the unit reopens memory at the next address without touching the store.

Both data paths use valid/ready. A word moves on the instruction output only in a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, the output word and its address stay put and nothing advances. The memory read stream moves only when `mem_rd_ready` is high. `mem_open` is a one-cycle command that the memory always accepts. It drops any word still pending from the old stream, and the first word of the new stream is the word at `mem_open_addr`. `redir_valid` and `redir_pc` are plain control pins.

Top module: `btc_fetch_top`

## Requirements
- R1: After reset, every store entry is invalid. In the first cycle after reset is released, `out_valid` is low, `mem_open` is high and `mem_open_addr` equals `RESET_PC`.
- R2: In sequential fetch, `out_valid` follows `mem_rd_valid`, `mem_rd_ready` follows `out_ready`, and each accepted word is followed by the word at the address 4 higher.
- R3: In a cycle with `redir_valid` high, `out_valid` and `mem_open` are low. The cycle after it is a lookup cycle for `redir_pc`.
- R4: A lookup that hits opens memory at target + 4*STREAM. It then presents the STREAM cached words at the target and the next addresses, one per accepted transfer, and holds `mem_rd_ready` low meanwhile.
- R5: After the last cached word is accepted, output continues from the memory stream at target + 4*STREAM. `out_valid` stays low until the memory has data.
- R6: A lookup that misses opens memory at the target and holds `out_valid` low until data returns. The entry becomes valid once STREAM words from the target onward have been accepted.
- R7: If a redirect arrives before a miss has delivered STREAM words, the entry stays invalid, and a later redirect to that target misses.
- R8: Accepting a word whose word index in its row (address bits [6:2] with ROW_WORDS=32) is ROW_WORDS-1 causes a reopen at the next address in the following cycle, with `out_valid` low. No entry is allocated.
- R9: While `out_valid` is high and `out_ready` low, `out_pc` and `out_data` keep their values into the next cycle unless a redirect arrives.
- R10: A redirect during cached playback drops the remaining cached words. The next cycle looks up the new target.
- R11: Misses allocate entries in round-robin order, so the (ENTRIES+1)-th distinct allocation evicts the oldest one.
- R12: `out_data` always equals the memory's code word at `out_pc`, whether it comes from the store or from the memory stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| redir_valid | input | 1 | Taken-branch redirect strobe |
| redir_pc | input | 32 | Redirect target address (word aligned) |
| out_valid | output | 1 | Instruction word available |
| out_ready | input | 1 | Consumer accepts the instruction word |
| out_pc | output | 32 | Address of the presented word |
| out_data | output | 32 | Presented instruction word |
| mem_open | output | 1 | Start a random access, one-cycle command |
| mem_open_addr | output | 32 | Address of the random access |
| mem_rd_valid | input | 1 | Memory stream word available |
| mem_rd_ready | output | 1 | Take the stream word and step to the next address |
| mem_rd_data | input | 32 | Memory stream word |

## Verification
A redirect held during one cycle shows its effect in the next cycle: that is the lookup cycle, with `mem_open` high and the hit or miss visible in `mem_open_addr`. On a hit, the first cached word appears one cycle after the lookup. Memory words pass through combinationally in the same cycle that `mem_rd_valid` rises, and a reopen at a row edge comes one cycle after the last word of the row is accepted. The bench drives its inputs after the falling edge and compares every output against its reference model slightly later in that same cycle. It then advances the model by exactly one cycle per clock, with the memory latency varied from 1 to 6 cycles, so every due-cycle is checked where it falls.

// File: rtl/btc_pkg.sv
`timescale 1ns/1ps
package btc_pkg;
  typedef enum logic [1:0] {
    FS_LOOK  = 2'd0,
    FS_ROW   = 2'd1,
    FS_CACHE = 2'd2,
    FS_MEM   = 2'd3
  } fetch_state_t;
endpackage

// File: rtl/btc_tag_match.sv
`timescale 1ns/1ps
module btc_tag_match #(
  parameter int ENTRIES = 32,
  parameter int TAG_W   = 30,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES*TAG_W-1:0] tags_flat,
  input  logic [ENTRIES-1:0]       valid_vec,
  input  logic [TAG_W-1:0]         key,
  output logic                     hit,
  output logic [IDX_W-1:0]         hit_idx
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid_vec[g] && (tags_flat[g*TAG_W +: TAG_W] == key);
  end

  always_comb begin
    hit     = |eq;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) hit_idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/btc_store.sv
`timescale 1ns/1ps
module btc_store #(
  parameter int ENTRIES = 32,
  parameter int STREAM  = 4,
  parameter int DATA_W  = 32,
  parameter int TAG_W   = 30,
  localparam int IDX_W  = $clog2(ENTRIES),
  localparam int WI_W   = $clog2(STREAM)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     alloc_en,
  input  logic [TAG_W-1:0]         alloc_tag,
  input  logic                     wr_en,
  input  logic [WI_W-1:0]          wr_word,
  input  logic [DATA_W-1:0]        wr_data,
  input  logic                     wr_last,
  input  logic [IDX_W-1:0]         rd_entry,
  input  logic [WI_W-1:0]          rd_word,
  output logic [DATA_W-1:0]        rd_data,
  output logic [ENTRIES*TAG_W-1:0] tags_flat,
  output logic [ENTRIES-1:0]       valid_vec
);
  logic [TAG_W-1:0]  tag_q  [ENTRIES];
  logic [DATA_W-1:0] data_q [ENTRIES][STREAM];
  logic [ENTRIES-1:0] valid_q;
  logic [IDX_W-1:0]   rr_q;
  logic [IDX_W-1:0]   fill_ent_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= '0;
      rr_q       <= '0;
      fill_ent_q <= '0;
    end else begin
      if (alloc_en) begin
        valid_q[rr_q] <= 1'b0;
        fill_ent_q    <= rr_q;
        rr_q          <= (rr_q == IDX_W'(ENTRIES - 1)) ? '0 : rr_q + 1'b1;
      end
      if (wr_en && wr_last) valid_q[fill_ent_q] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_en) tag_q[rr_q] <= alloc_tag;
    if (wr_en) data_q[fill_ent_q][wr_word] <= wr_data;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_flat
    assign tags_flat[g*TAG_W +: TAG_W] = tag_q[g];
  end

  assign valid_vec = valid_q;
  assign rd_data   = data_q[rd_entry][rd_word];
endmodule

// File: rtl/btc_fetch_top.sv
`timescale 1ns/1ps
module btc_fetch_top #(
  parameter logic [31:0] RESET_PC  = 32'h0000_1000,
  parameter int          ENTRIES   = 32,
  parameter int          STREAM    = 4,
  parameter int          ROW_WORDS = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        redir_valid,
  input  logic [31:0] redir_pc,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_pc,
  output logic [31:0] out_data,
  output logic        mem_open,
  output logic [31:0] mem_open_addr,
  input  logic        mem_rd_valid,
  output logic        mem_rd_ready,
  input  logic [31:0] mem_rd_data
);
  import btc_pkg::*;

  localparam int          IDX_W  = $clog2(ENTRIES);
  localparam int          WI_W   = $clog2(STREAM);
  localparam int          ROW_IW = $clog2(ROW_WORDS);
  localparam int          TAG_W  = 30;
  localparam logic [31:0] SPAN   = 32'(STREAM * 4);

  fetch_state_t      state_q;
  logic [31:0]       pc_q;
  logic [WI_W-1:0]   widx_q;
  logic [IDX_W-1:0]  ent_q;
  logic              filling_q;
  logic [WI_W-1:0]   fill_q;

  logic                     hit;
  logic [IDX_W-1:0]         hit_idx;
  logic [31:0]              rd_data;
  logic [ENTRIES*TAG_W-1:0] tags_flat;
  logic [ENTRIES-1:0]       valid_vec;
  logic                     hs;
  logic                     alloc_en;
  logic                     wr_en;
  logic                     wr_last;
  logic                     row_last;
  logic                     cache_mode;

  btc_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) match_i (
    .tags_flat (tags_flat),
    .valid_vec (valid_vec),
    .key       (pc_q[31:2]),
    .hit       (hit),
    .hit_idx   (hit_idx)
  );

  btc_store #(.ENTRIES(ENTRIES), .STREAM(STREAM), .DATA_W(32), .TAG_W(TAG_W)) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_en  (alloc_en),
    .alloc_tag (pc_q[31:2]),
    .wr_en     (wr_en),
    .wr_word   (fill_q),
    .wr_data   (mem_rd_data),
    .wr_last   (wr_last),
    .rd_entry  (ent_q),
    .rd_word   (widx_q),
    .rd_data   (rd_data),
    .tags_flat (tags_flat),
    .valid_vec (valid_vec)
  );

  assign row_last   = &pc_q[ROW_IW+1:2];
  assign cache_mode = (state_q == FS_CACHE);
  assign out_pc     = pc_q;

  always_comb begin
    out_valid     = 1'b0;
    out_data      = mem_rd_data;
    mem_open      = 1'b0;
    mem_open_addr = pc_q;
    mem_rd_ready  = 1'b0;
    if (!redir_valid) begin
      unique case (state_q)
        FS_LOOK: begin
          mem_open = 1'b1;
          if (hit) mem_open_addr = pc_q + SPAN;
        end
        FS_ROW:   mem_open = 1'b1;
        FS_CACHE: begin
          out_valid = 1'b1;
          out_data  = rd_data;
        end
        FS_MEM: begin
          out_valid    = mem_rd_valid;
          mem_rd_ready = out_ready;
        end
        default: ;
      endcase
    end
  end

  assign hs       = out_valid && out_ready;
  assign alloc_en = !redir_valid && (state_q == FS_LOOK) && !hit;
  assign wr_en    = (state_q == FS_MEM) && hs && filling_q;
  assign wr_last  = (fill_q == WI_W'(STREAM - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= FS_ROW;
      pc_q      <= RESET_PC;
      widx_q    <= '0;
      ent_q     <= '0;
      filling_q <= 1'b0;
      fill_q    <= '0;
    end else if (redir_valid) begin
      state_q   <= FS_LOOK;
      pc_q      <= redir_pc;
      filling_q <= 1'b0;
    end else begin
      unique case (state_q)
        FS_LOOK: begin
          if (hit) begin
            state_q <= FS_CACHE;
            ent_q   <= hit_idx;
            widx_q  <= '0;
          end else begin
            state_q   <= FS_MEM;
            filling_q <= 1'b1;
            fill_q    <= '0;
          end
        end
        FS_ROW: state_q <= FS_MEM;
        FS_CACHE: begin
          if (hs) begin
            pc_q   <= pc_q + 32'd4;
            widx_q <= widx_q + 1'b1;
            if (widx_q == WI_W'(STREAM - 1)) state_q <= FS_MEM;
          end
        end
        FS_MEM: begin
          if (hs) begin
            pc_q <= pc_q + 32'd4;
            if (wr_en) begin
              fill_q <= fill_q + 1'b1;
              if (wr_last) filling_q <= 1'b0;
            end
            if (row_last) state_q <= FS_ROW;
          end
        end
        default: state_q <= FS_ROW;
      endcase
    end
  end
endmodule

// File: rtl/btc_fetch_chk.sv
`timescale 1ns/1ps
module btc_fetch_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        redir_valid,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_pc,
  input logic        mem_open,
  input logic        mem_rd_ready,
  input logic        cache_mode
);
  // R3
  redir_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> (!out_valid && !mem_open));

  // R4
  cache_noread_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cache_mode |-> !mem_rd_ready);

  // R9
  hold_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (redir_valid || (out_valid && $stable(out_pc))));

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |=> (!out_valid || (out_pc == $past(out_pc) + 32'd4)));

  // R6
  open_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_open |-> !out_valid);
endmodule

bind btc_fetch_top btc_fetch_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .redir_valid  (redir_valid),
  .out_valid    (out_valid),
  .out_ready    (out_ready),
  .out_pc       (out_pc),
  .mem_open     (mem_open),
  .mem_rd_ready (mem_rd_ready),
  .cache_mode   (cache_mode)
);

// File: tb/btc_fetch_tb.sv
`timescale 1ns/1ps
module btc_fetch_top_tb_top;
  localparam logic [31:0] RST_PC = 32'h0000_1000;
  localparam int ENT = 32;
  localparam int SL  = 4;
  localparam int M_LOOK = 0, M_ROW = 1, M_CACHE = 2, M_MEM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic redir_valid = 1'b0;
  logic [31:0] redir_pc = '0;
  logic out_valid, out_ready = 1'b0;
  logic [31:0] out_pc, out_data;
  logic mem_open;
  logic [31:0] mem_open_addr;
  logic mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_rd_data;

  always #2.5 clk = ~clk;

  btc_fetch_top #(.RESET_PC(RST_PC), .ENTRIES(ENT), .STREAM(SL), .ROW_WORDS(32)) dut_i (
    .clk(clk), .rst_n(rst_n), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .out_valid(out_valid), .out_ready(out_ready), .out_pc(out_pc), .out_data(out_data),
    .mem_open(mem_open), .mem_open_addr(mem_open_addr), .mem_rd_valid(mem_rd_valid),
    .mem_rd_ready(mem_rd_ready), .mem_rd_data(mem_rd_data)
  );

  function automatic logic [31:0] code_at(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16]} ^ 32'h1357_9BDF;
  endfunction

  // memory model
  logic [31:0] mem_ptr = '0, nx_ptr = '0;
  int mem_wait = 0, nx_wait = 0;
  bit mem_opened = 0, nx_opened = 0;
  int lat_tab[5] = '{3, 1, 6, 2, 4};
  int li = 0;
  assign mem_rd_valid = mem_opened && (mem_wait == 0);
  assign mem_rd_data  = code_at(mem_ptr);

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_opened <= 0; mem_wait <= 0; mem_ptr <= '0;
    end else begin
      mem_opened <= nx_opened; mem_wait <= nx_wait; mem_ptr <= nx_ptr;
    end
  end

  // reference model
  int m_mode = M_ROW;
  logic [31:0] m_pc = RST_PC;
  logic [31:0] cq[$];
  logic [31:0] ctag[ENT];
  bit cval[ENT];
  int rr = 0, fe = 0, fcnt = 0;
  bit filling = 0;
  string ph = "R1";
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  bit p_hold = 0;
  logic [31:0] p_pc = '0, p_data = '0;

  function automatic bit m_hit(input logic [31:0] a);
    for (int e = 0; e < ENT; e++) if (cval[e] && ctag[e] == a) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input bit rv, input logic [31:0] rt, input bit rdy);
    bit e_valid, e_open, e_rdy, hs, h;
    logic [31:0] e_pc, e_oaddr;
    string tag, rq;
    redir_valid = rv; redir_pc = rt; out_ready = rdy;
    #1;
    e_valid = 0; e_open = 0; e_oaddr = '0; e_pc = '0; h = 0; tag = "R2";
    if (rv) tag = "R3";
    else begin
      case (m_mode)
        M_LOOK: begin
          h = m_hit(m_pc); e_open = 1;
          e_oaddr = h ? m_pc + 32'(4 * SL) : m_pc;
          tag = h ? "R4" : "R6";
        end
        M_ROW: begin e_open = 1; e_oaddr = m_pc; tag = "R8"; end
        M_CACHE: begin e_valid = 1; e_pc = cq[0]; tag = "R4"; end
        default: begin e_valid = mem_rd_valid; e_pc = m_pc; tag = "R2"; end
      endcase
    end
    e_rdy = !rv && (m_mode == M_MEM) && rdy;
    rq = {tag, "/", ph};
    chk(out_valid === e_valid, rq, "out_valid", 32'(out_valid), 32'(e_valid));
    if (e_valid && out_valid) begin
      chk(out_pc === e_pc, rq, "out_pc", out_pc, e_pc);
      chk(out_data === code_at(e_pc), {"R12/", ph}, "out_data", out_data, code_at(e_pc));
    end
    chk(mem_open === e_open, rq, "mem_open", 32'(mem_open), 32'(e_open));
    if (e_open) chk(mem_open_addr === e_oaddr, rq, "mem_open_addr", mem_open_addr, e_oaddr);
    chk(mem_rd_ready === e_rdy, rq, "mem_rd_ready", 32'(mem_rd_ready), 32'(e_rdy));
    // R9 explicit hold check
    if (p_hold && !rv) begin
      chk(out_valid === 1'b1, "R9", "hold valid", 32'(out_valid), 32'd1);
      chk(out_pc === p_pc, "R9", "hold pc", out_pc, p_pc);
      chk(out_data === p_data, "R9", "hold data", out_data, p_data);
    end
    p_hold = out_valid && !rdy; p_pc = out_pc; p_data = out_data;
    hs = e_valid && rdy;
    // memory next
    nx_opened = mem_opened; nx_wait = mem_wait; nx_ptr = mem_ptr;
    if (mem_open) begin
      nx_opened = 1; nx_ptr = mem_open_addr; nx_wait = lat_tab[li]; li = (li + 1) % 5;
    end else if (mem_wait > 0) nx_wait = mem_wait - 1;
    else if (mem_rd_valid && mem_rd_ready) nx_ptr = mem_ptr + 32'd4;
    // model next
    if (rv) begin
      m_mode = M_LOOK; m_pc = rt; cq.delete(); filling = 0;
    end else begin
      case (m_mode)
        M_LOOK: begin
          if (h) begin
            for (int i = 0; i < SL; i++) cq.push_back(m_pc + 32'(4 * i));
            m_pc = m_pc + 32'(4 * SL); m_mode = M_CACHE;
          end else begin
            ctag[rr] = m_pc; cval[rr] = 0; fe = rr; rr = (rr + 1) % ENT;
            filling = 1; fcnt = 0; m_mode = M_MEM;
          end
        end
        M_ROW: m_mode = M_MEM;
        M_CACHE: if (hs) begin
          void'(cq.pop_front());
          if (cq.size() == 0) m_mode = M_MEM;
        end
        default: if (hs) begin
          if (filling) begin
            fcnt++;
            if (fcnt == SL) begin cval[fe] = 1; filling = 0; end
          end
          if (((m_pc >> 2) & 32'd31) == 32'd31) m_mode = M_ROW;
          m_pc = m_pc + 32'd4;
        end
      endcase
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=%0d exp=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] tg[4];
    logic [15:0] lfsr;
    for (int e = 0; e < ENT; e++) begin cval[e] = 0; ctag[e] = '0; end
    tg[0] = 32'h2000; tg[1] = 32'h3040; tg[2] = 32'h10A00; tg[3] = 32'h507C;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state and first random access to the reset vector
    ph = "R1";
    step(0, '0, 1);
    ph = "R2";
    repeat (45) step(0, '0, 1);
    ph = "R9";
    for (int i = 0; i < 20; i++) step(0, '0, (i % 3) != 0);
    ph = "R6";
    step(1, 32'h2000, 1); repeat (14) step(0, '0, 1);
    step(1, 32'h3040, 1); repeat (14) step(0, '0, 1);
    ph = "R5";
    step(1, 32'h2000, 1); repeat (14) step(0, '0, 1);
    ph = "R9";
    step(1, 32'h3040, 1);
    for (int i = 0; i < 16; i++) step(0, '0, i[0]);
    ph = "R7";
    step(1, 32'h4000, 1); repeat (3) step(0, '0, 1);
    step(1, 32'h4800, 1); repeat (14) step(0, '0, 1);
    step(1, 32'h4000, 1); repeat (14) step(0, '0, 1);
    ph = "R10";
    step(1, 32'h2000, 1); repeat (2) step(0, '0, 1);
    step(1, 32'h3040, 1); repeat (12) step(0, '0, 1);
    ph = "R8";
    step(1, 32'h507C, 1); repeat (14) step(0, '0, 1);
    step(1, 32'h507C, 1); repeat (12) step(0, '0, 1);
    ph = "R11";
    for (int i = 0; i < 34; i++) begin
      step(1, 32'h10000 + 32'(i * 32'h200), 1);
      repeat (14) step(0, '0, 1);
    end
    step(1, 32'h10000, 1); repeat (12) step(0, '0, 1);
    step(1, 32'h10A00, 1); repeat (12) step(0, '0, 1);
    ph = "R12";
    lfsr = 16'hACE1;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 23 == 0) step(1, tg[(i / 23) % 4], lfsr[0] | lfsr[1]);
      else step(0, '0, lfsr[0] | lfsr[1]);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule